// File: doc/BRIEF.md
# Keystream-Decrypting Instruction Fetch Controller

This block is the fetch stage of a small in-order 32-bit pipeline that runs encrypted code from an uncached instruction memory. Every word read from memory is a ciphertext. The block combines it with the next word of keystream from an external stream-cipher core before the word goes to decode, so one instruction is unmasked per cycle while the stream runs.

The code is split into blocks that can only be entered at their first word. A taken branch therefore starts a new stream. The controller works out an 80-bit initialisation value (IV) for the target and pulses the cipher's init strobe with it. Fetch is then frozen, with a zero NOP and a low valid going to decode, until the cipher reports ready. There are three ways to form the IV:

- The IV is a configured base value added to the target address. Code size does not change.
- The IV is loaded from three words stored at the head of the target block. Those words are skipped and never executed.
- The stored value is XORed with the target address.

Sequential fall-through keeps the current stream. Reset acts as a branch to a fixed start address. A taken branch is only sampled while fetch is running.

Top module: `enc_fetch_ctrl`

## Requirements
- R1: While running, each cycle without a taken branch delivers one word with `dec_valid` high. `dec_instr` equals `imem_rdata ^ cph_ks` and `dec_pc` equals the address read. Consecutive deliveries advance the address by 4.
- R2: A taken branch sampled while running delivers nothing in that cycle. It causes exactly one `cph_init` pulse for the new target, followed by a stall.
- R3: After `cph_init`, `stall` stays high until `cph_ready` is seen. While stalled, `dec_valid` is 0 and `dec_instr` is all zeros. The first delivery comes no earlier than the cipher's initialisation latency.
- R4: For `iv_mode` 0, the IV on `cph_iv` is `iv_base + target`, with the target zero-extended to 80 bits. The first word executed is at the target.
- R5: For `iv_mode` 1, the controller reads the words at target, target+4 and target+8. The IV is {word0, word1, word2[31:16]}. Execution starts at target+12, and the three slot words are never delivered.
- R6: For `iv_mode` 2, the IV is the stored value of R5 XORed with the zero-extended target. Execution starts at target+12.
- R7: Fall-through into the next address causes no new `cph_init`, and the keystream simply continues.
- R8: During reset, `stall` is 1, `dec_valid` is 0, `dec_instr` is 0 and `cph_init` is 0. After reset, the block re-keys for `RESET_PC` (0x100) using the mode present on `iv_mode`.
- R9: `cph_next` is high exactly in the cycles where a word is delivered.
- R10: `iv_mode` 3 forms the IV as in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| iv_mode | input | 2 | IV scheme: 0 address, 1 stored, 2 stored XOR address, 3 address |
| iv_base | input | 80 | Per-program IV base for the address scheme |
| br_taken | input | 1 | Taken branch or jump this cycle |
| br_target | input | 32 | Branch target byte address |
| imem_addr | output | 32 | Instruction memory read address |
| imem_rdata | input | 32 | Ciphertext word at `imem_addr` (combinational read) |
| cph_init | output | 1 | One-cycle cipher re-initialise strobe |
| cph_iv | output | 80 | IV presented with `cph_init` |
| cph_ready | input | 1 | Cipher has finished initialisation |
| cph_ks | input | 32 | Current keystream word |
| cph_next | output | 1 | Advance keystream by one word |
| dec_instr | output | 32 | Plaintext instruction to decode, zero when not valid |
| dec_pc | output | 32 | Address of the delivered instruction |
| dec_valid | output | 1 | Instruction delivered this cycle |
| stall | output | 1 | Fetch frozen while the stream is being set up |

## Verification
The bench aims at the cycle in which a branch is taken. A design that lets the word fetched in that cycle through would hand decode a word unmasked with the old stream, and the squash check catches it. For the stored-IV schemes, the bench checks that the first delivered address is target+12 and that the IV uses the upper half of the third slot word. A design that executed the slots or took the wrong half would show a wrong first address or garbage plaintext. Long fall-through runs, checked against the plaintext and the count of init pulses, expose a design that re-keys or stops advancing the keystream without a branch. The stall window is checked both for length and for zeroed output, so an early release or leaking data is visible.

// File: rtl/efc_pkg.sv
package efc_pkg;

  typedef enum logic [1:0] {
    IVM_ADDR     = 2'd0,
    IVM_SLOT     = 2'd1,
    IVM_MIX      = 2'd2,
    IVM_ADDR_ALT = 2'd3
  } ivmode_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_SLOT,
    ST_KEY,
    ST_WAIT,
    ST_RUN
  } fstate_e;

  // Schemes that read IV words from the head of the target block.
  function automatic logic uses_slots(ivmode_e m);
    return (m == IVM_SLOT) || (m == IVM_MIX);
  endfunction

endpackage

// File: rtl/efc_iv_form.sv
module efc_iv_form
  import efc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IVW = 80
) (
  input  ivmode_e          mode,
  input  logic [IVW-1:0]   base,
  input  logic [IVW-1:0]   stored,
  input  logic [AW-1:0]    target,
  output logic [IVW-1:0]   iv
);

  localparam int PAD = IVW - AW;

  logic [IVW-1:0] tgt_ext;

  assign tgt_ext = {{PAD{1'b0}}, target};

  always_comb begin
    unique case (mode)
      IVM_SLOT: iv = stored;
      IVM_MIX:  iv = stored ^ tgt_ext;
      default:  iv = base + tgt_ext;   // address scheme, also code 3
    endcase
  end

endmodule

// File: rtl/efc_slot_gather.sv
module efc_slot_gather #(
  parameter int WW  = 32,
  parameter int IVW = 80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_en,
  input  logic [((((IVW+WW-1)/WW) > 1) ? $clog2((IVW+WW-1)/WW) : 1)-1:0] cap_idx,
  input  logic [WW-1:0]         word,
  output logic [IVW-1:0]        stored_iv
);

  localparam int SLOTS = (IVW + WW - 1) / WW;
  localparam int CW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // Slot 0 fills the top of the IV; the last slot keeps only its upper bits.
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam int HI   = IVW - g * WW;
    localparam int KEEP = (HI < WW) ? HI : WW;

    logic [KEEP-1:0] q;
    logic            hit;

    assign hit = cap_en && (cap_idx == CW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= word[WW-1 -: KEEP];
      end
    end

    assign stored_iv[HI-1 -: KEEP] = q;
  end

endmodule

// File: rtl/efc_fsm.sv
module efc_fsm
  import efc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            WW       = 32,
  parameter int            SLOTS    = 3,
  parameter int            CW       = 2,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ivmode_e        mode_in,
  input  logic           br_taken,
  input  logic [AW-1:0]  br_target,
  input  logic           cph_ready,
  output logic [AW-1:0]  fetch_addr,
  output logic [AW-1:0]  pc_o,
  output logic [AW-1:0]  tgt_o,
  output ivmode_e        mode_o,
  output logic [CW-1:0]  slot_idx_o,
  output logic           slot_cap_o,
  output logic           key_o,
  output logic           run_o
);

  localparam int            WB         = WW / 8;
  localparam logic [AW-1:0] STEP       = AW'(WB);
  localparam logic [AW-1:0] SLOT_BYTES = AW'(SLOTS * WB);
  localparam logic [CW-1:0] LAST_SLOT  = CW'(SLOTS - 1);

  fstate_e       st_q,  st_d;
  logic [AW-1:0] pc_q,  pc_d;
  logic [AW-1:0] tgt_q, tgt_d;
  ivmode_e       md_q,  md_d;
  logic [CW-1:0] cnt_q, cnt_d;

  logic          redir;
  logic [AW-1:0] redir_tgt;
  logic          pc_en;

  // Next-state logic
  always_comb begin
    redir     = (st_q == ST_BOOT) || ((st_q == ST_RUN) && br_taken);
    redir_tgt = (st_q == ST_BOOT) ? tgt_q : br_target;

    st_d  = st_q;
    pc_d  = pc_q;
    tgt_d = tgt_q;
    md_d  = md_q;
    cnt_d = cnt_q;

    if (redir) begin
      tgt_d = redir_tgt;
      md_d  = mode_in;
      cnt_d = '0;
      if (uses_slots(mode_in)) begin
        st_d = ST_SLOT;
        pc_d = redir_tgt + SLOT_BYTES;
      end else begin
        st_d = ST_KEY;
        pc_d = redir_tgt;
      end
    end else begin
      unique case (st_q)
        ST_SLOT: begin
          if (cnt_q == LAST_SLOT) st_d = ST_KEY;
          else                    cnt_d = cnt_q + CW'(1);
        end
        ST_KEY:  st_d = ST_WAIT;
        ST_WAIT: if (cph_ready) st_d = ST_RUN;
        ST_RUN:  pc_d = pc_q + STEP;
        default: ;
      endcase
    end
  end

  assign pc_en = redir || (st_q == ST_RUN);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_BOOT;
      tgt_q <= RESET_PC;
      md_q  <= IVM_ADDR;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      md_q  <= md_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign fetch_addr = (st_q == ST_SLOT) ? (tgt_q + AW'(cnt_q) * STEP) : pc_q;
  assign pc_o       = pc_q;
  assign tgt_o      = tgt_q;
  assign mode_o     = md_q;
  assign slot_idx_o = cnt_q;
  assign slot_cap_o = (st_q == ST_SLOT);
  assign key_o      = (st_q == ST_KEY);
  assign run_o      = (st_q == ST_RUN);

endmodule

// File: rtl/enc_fetch_ctrl.sv
module enc_fetch_ctrl
  import efc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            WW       = 32,
  parameter int            IVW      = 80,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      iv_mode,
  input  logic [IVW-1:0]  iv_base,
  input  logic            br_taken,
  input  logic [AW-1:0]   br_target,
  output logic [AW-1:0]   imem_addr,
  input  logic [WW-1:0]   imem_rdata,
  output logic            cph_init,
  output logic [IVW-1:0]  cph_iv,
  input  logic            cph_ready,
  input  logic [WW-1:0]   cph_ks,
  output logic            cph_next,
  output logic [WW-1:0]   dec_instr,
  output logic [AW-1:0]   dec_pc,
  output logic            dec_valid,
  output logic            stall
);

  localparam int SLOTS = (IVW + WW - 1) / WW;
  localparam int CW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  ivmode_e        mode_in;
  ivmode_e        mode_q;
  logic [AW-1:0]  pc_q;
  logic [AW-1:0]  tgt_q;
  logic [CW-1:0]  slot_idx;
  logic           slot_cap;
  logic           key_st;
  logic           run_st;
  logic [IVW-1:0] stored_iv;
  logic           issue;

  assign mode_in = ivmode_e'(iv_mode);

  efc_fsm #(
    .AW       (AW),
    .WW       (WW),
    .SLOTS    (SLOTS),
    .CW       (CW),
    .RESET_PC (RESET_PC)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_in    (mode_in),
    .br_taken   (br_taken),
    .br_target  (br_target),
    .cph_ready  (cph_ready),
    .fetch_addr (imem_addr),
    .pc_o       (pc_q),
    .tgt_o      (tgt_q),
    .mode_o     (mode_q),
    .slot_idx_o (slot_idx),
    .slot_cap_o (slot_cap),
    .key_o      (key_st),
    .run_o      (run_st)
  );

  efc_slot_gather #(
    .WW  (WW),
    .IVW (IVW)
  ) gather_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (slot_cap),
    .cap_idx   (slot_idx),
    .word      (imem_rdata),
    .stored_iv (stored_iv)
  );

  efc_iv_form #(
    .AW  (AW),
    .IVW (IVW)
  ) form_i (
    .mode   (mode_q),
    .base   (iv_base),
    .stored (stored_iv),
    .target (tgt_q),
    .iv     (cph_iv)
  );

  // A branch in a running cycle squashes the word read in that cycle.
  assign issue     = run_st && !br_taken;
  assign dec_valid = issue;
  assign cph_next  = issue;
  assign dec_instr = issue ? (imem_rdata ^ cph_ks) : '0;
  assign dec_pc    = pc_q;
  assign cph_init  = key_st;
  assign stall     = !run_st;

endmodule

// File: rtl/enc_fetch_chk.sv
module enc_fetch_chk #(
  parameter int AW = 32,
  parameter int WW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_taken,
  input logic          cph_init,
  input logic          cph_next,
  input logic [WW-1:0] dec_instr,
  input logic [AW-1:0] dec_pc,
  input logic          dec_valid,
  input logic          stall
);

  localparam logic [AW-1:0] STEP = AW'(WW / 8);

  a_r3_nop_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (dec_instr == '0 && !dec_valid));

  a_r9_advance_per_word: assert property (@(posedge clk) disable iff (!rst_n)
    cph_next == dec_valid);

  a_r2_branch_restalls: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && br_taken) |=> stall);

  a_r2_branch_squash: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && br_taken) |-> !dec_valid);

  a_r1_sequential_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(dec_valid)) |-> (dec_pc == $past(dec_pc) + STEP));

  a_r7_init_only_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    cph_init |-> stall);

  a_r3_init_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    cph_init |=> (stall && !cph_init));

endmodule

bind enc_fetch_ctrl enc_fetch_chk #(.AW(AW), .WW(WW)) chk_i (.*);

// File: tb/enc_fetch_ctrl_tb.sv
`timescale 1ns/1ps
module enc_fetch_ctrl_tb_top;

  localparam int LAT = 18;
  localparam logic [79:0] BASE = 80'h3C1F_0A96_77E2_D405_B8E1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  iv_mode = 2'd0;
  logic [79:0] iv_base = BASE;
  logic        br_taken = 1'b0;
  logic [31:0] br_target = '0;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic        cph_init;
  logic [79:0] cph_iv;
  logic        cph_ready;
  logic [31:0] cph_ks;
  logic        cph_next;
  logic [31:0] dec_instr;
  logic [31:0] dec_pc;
  logic        dec_valid;
  logic        stall;

  int n_chk = 0;
  int n_fail = 0;
  int n_init = 0;
  logic [79:0] last_iv = '0;
  logic [31:0] ram [0:1023];

  always #5 clk = ~clk;

  enc_fetch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .iv_mode(iv_mode), .iv_base(iv_base),
    .br_taken(br_taken), .br_target(br_target), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .cph_init(cph_init), .cph_iv(cph_iv),
    .cph_ready(cph_ready), .cph_ks(cph_ks), .cph_next(cph_next),
    .dec_instr(dec_instr), .dec_pc(dec_pc), .dec_valid(dec_valid),
    .stall(stall)
  );

  function automatic logic [31:0] kfun(logic [79:0] iv, logic [31:0] idx);
    return iv[31:0] ^ iv[63:32] ^ {iv[79:64], iv[79:64]} ^
           ((idx + 32'd1) * 32'h9E37_79B9) ^ {idx[15:0], idx[31:16]};
  endfunction

  function automatic logic [31:0] plain(logic [31:0] a);
    return a * 32'h0100_0193 + 32'h1357_9BDF;
  endfunction

  // Behavioural stand-in for the stream-cipher core
  logic [79:0] ks_iv;
  logic [31:0] ks_idx;
  int          ks_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ks_iv <= '0; ks_idx <= '0; ks_cnt <= 0; cph_ready <= 1'b0;
    end else if (cph_init) begin
      ks_iv <= cph_iv; ks_idx <= '0; ks_cnt <= LAT; cph_ready <= 1'b0;
    end else begin
      if (ks_cnt > 1) ks_cnt <= ks_cnt - 1;
      else if (ks_cnt == 1) begin ks_cnt <= 0; cph_ready <= 1'b1; end
      if (cph_next) ks_idx <= ks_idx + 32'd1;
    end
  end
  assign cph_ks     = kfun(ks_iv, ks_idx);
  assign imem_rdata = ram[imem_addr[11:2]];

  always_ff @(posedge clk) begin
    if (cph_init) begin
      n_init  <= n_init + 1;
      last_iv <= cph_iv;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Encrypt one block into memory and return the IV the design must form
  task automatic prep_block(input logic [31:0] addr, input int mode,
                            input int nbody, output logic [79:0] iv);
    logic [79:0] st;
    logic [31:0] body;
    st   = {addr, ~addr, 16'h5A5A};
    body = addr;
    if (mode == 1 || mode == 2) begin
      ram[addr[11:2]]       = st[79:48];
      ram[addr[11:2] + 1]   = st[47:16];
      ram[addr[11:2] + 2]   = {st[15:0], 16'hBEEF};
      body = addr + 32'd12;
      iv   = (mode == 1) ? st : (st ^ {48'd0, addr});
    end else begin
      iv = BASE + {48'd0, addr};
    end
    for (int k = 0; k < nbody; k++) begin
      logic [31:0] a;
      a = body + 32'(4 * k);
      ram[a[11:2]] = plain(a) ^ kfun(iv, 32'(k));
    end
  endtask

  task automatic expect_block(input logic [31:0] start, input logic [79:0] iv,
                              input int n, input int init0, input string req);
    int got = 0;
    int sc  = 0;
    logic [31:0] epc = start;
    while (got < n) begin
      @(negedge clk);
      if (dec_valid) begin
        if (got == 0) begin
          chk(sc >= LAT, "R3", "stall length", 80'(sc), 80'(LAT));
          chk(n_init == init0 + 1, "R2", "init pulses", 80'(n_init), 80'(init0 + 1));
          chk(last_iv == iv, req, "cipher IV", last_iv, iv);
          chk(dec_pc == epc, req, "first address", 80'(dec_pc), 80'(epc));
        end else begin
          chk(dec_pc == epc, "R1", "decode address", 80'(dec_pc), 80'(epc));
        end
        chk(dec_instr == plain(epc), "R1", "plaintext", 80'(dec_instr), 80'(plain(epc)));
        chk(cph_next, "R9", "keystream advance", 80'(cph_next), 80'(1));
        got++;
        epc += 32'd4;
      end else if (stall) begin
        sc++;
        chk(dec_instr == '0, "R3", "NOP while stalled", 80'(dec_instr), 80'(0));
        chk(!cph_next, "R9", "no advance while stalled", 80'(cph_next), 80'(0));
      end
    end
  endtask

  task automatic do_branch(input logic [31:0] target, input logic [1:0] mode);
    @(negedge clk);
    while (stall) @(negedge clk);
    iv_mode   = mode;
    br_target = target;
    br_taken  = 1'b1;
    #1;
    chk(!dec_valid, "R2", "word squashed on branch", 80'(dec_valid), 80'(0));
    @(posedge clk);
    #1 br_taken = 1'b0;
  endtask

  task automatic t_reset_boot(input logic [79:0] iv);
    rst_n   = 1'b0;
    iv_mode = 2'd0;
    repeat (3) @(negedge clk);
    chk(stall == 1'b1, "R8", "stall in reset", 80'(stall), 80'(1));
    chk(!dec_valid, "R8", "valid in reset", 80'(dec_valid), 80'(0));
    chk(dec_instr == '0, "R8", "instr in reset", 80'(dec_instr), 80'(0));
    chk(!cph_init, "R8", "init in reset", 80'(cph_init), 80'(0));
    rst_n = 1'b1;
    expect_block(32'h100, iv, 14, 0, "R8");
    chk(n_init == 1, "R7", "no re-key on fall-through", 80'(n_init), 80'(1));
  endtask

  task automatic t_branch(input logic [31:0] target, input logic [1:0] mode,
                          input logic [31:0] start, input logic [79:0] iv,
                          input string req);
    int i0;
    i0 = n_init;
    do_branch(target, mode);
    expect_block(start, iv, 8, i0, req);
  endtask

  initial begin
    logic [79:0] iv0, iv1, iv2, iv3, iv4;
    for (int i = 0; i < 1024; i++) ram[i] = '0;
    prep_block(32'h100, 0, 24, iv0);
    prep_block(32'h200, 0, 14, iv1);
    prep_block(32'h300, 1, 14, iv2);
    prep_block(32'h400, 2, 14, iv3);
    prep_block(32'h500, 3, 14, iv4);
    t_reset_boot(iv0);
    t_branch(32'h200, 2'd0, 32'h200, iv1, "R4");
    t_branch(32'h300, 2'd1, 32'h30C, iv2, "R5");
    t_branch(32'h400, 2'd2, 32'h40C, iv3, "R6");
    t_branch(32'h500, 2'd3, 32'h500, iv4, "R10");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule